// File: doc/BRIEF.md
# Reaction Timer Core with Saturating Decimal Count

This block times how long a person takes to answer a visual cue and sorts the result into one of three speed classes. A free-running prescaler turns the system clock into a one-clock tick. While the cue input is high and no answer has been captured, every tick adds one to a three-digit packed-BCD count. The count stops at 999 and stays there. The digits can go straight to a decimal display, because no binary-to-decimal conversion is needed.

The first answer pulse is latched into a sticky flag, and that flag freezes the count. An answer that arrives while the cue is low is also latched into an error flag. The start input clears the timer for a new attempt, exactly as reset does. The hundreds digit on its own selects the speed class. With the default prescaler setting and a 100 MHz clock, one count is 500 µs.

Top module: `reaction_timer_core`

## Requirements
- R1: The count is held in three BCD digits (hundreds, tens, ones), each 0..9. An enabled tick adds exactly one to the decimal value. A digit steps from 9 back to 0 and carries into the next digit only when all lower digits read 9.
- R2: When the count reads 999, `sat_flag` is high and further enabled ticks leave all digits unchanged. Only a clear returns the count to 000.
- R3: The prescaler restarts on a clear and produces a tick every PRESCALE_TERM+1 clocks. The first count increment happens on the (PRESCALE_TERM+1)th rising edge after the clearing edge.
- R4: A tick advances the count only while `cue_on` is high and `answered` is low. With `cue_on` low the count does not move.
- R5: An `answer_in` pulse sets `answered` on the next edge. `answered` stays set until a clear, and the count holds from then on. A tick sampled on the same edge as the answer still counts.
- R6: An `answer_in` pulse sampled while `cue_on` is low sets `early_err`, which stays set until a clear. An answer while `cue_on` is high never sets it.
- R7: A high `start_in` on a rising edge clears the count, the prescaler, `answered` and `early_err`, with the same effect as `rst`.
- R8: Reset is synchronous and active high, and it overrides every other input. While it is held, the digits read 000 and both flags are low.
- R9: The class depends only on the hundreds digit. `rate_fast` is high for 0..3, `rate_med` for 4..7 and `rate_slow` for 8..9. Exactly one of the three is high at all times, and a class bit changes in the same cycle as the hundreds digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Begin a new attempt; clears all timer state |
| cue_on | input | 1 | High while the visual cue is lit |
| answer_in | input | 1 | Answer button pulse |
| digit_hun | output | 4 | Hundreds BCD digit |
| digit_ten | output | 4 | Tens BCD digit |
| digit_one | output | 4 | Ones BCD digit |
| sat_flag | output | 1 | Count has reached 999 |
| answered | output | 1 | Sticky answer-captured flag |
| early_err | output | 1 | Sticky early-answer error flag |
| rate_fast | output | 1 | Hundreds digit 0..3 |
| rate_med | output | 1 | Hundreds digit 4..7 |
| rate_slow | output | 1 | Hundreds digit 8..9 |

## Verification
Every stored result lands one edge after the input that causes it. The flags and a cleared count appear on the edge that samples the answer, the start or the reset. A count increment appears on the edge that samples a tick, and ticks fall on edges PRESCALE_TERM+1, 2(PRESCALE_TERM+1) and so on after a clear. The class bits follow the hundreds digit with no extra delay. The bench drives its inputs, waits for one rising edge, moves its own edge-by-edge reference model forward, and samples one nanosecond later, so each comparison falls in the cycle where the result is due. The first-tick timing and the tick that coincides with an answer are each checked at that exact edge.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int unsigned DIGIT_W      = 4;
    localparam int unsigned NUM_DIGITS   = 3;
    localparam int unsigned DEFAULT_TERM = 32'h0000_C34F;

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t hun;
        bcd_t ten;
        bcd_t one;
    } bcd3_t;

    typedef struct packed {
        logic answered;
        logic early_err;
    } flags_t;

    typedef enum logic [2:0] {
        RATE_FAST = 3'b001,
        RATE_MED  = 3'b010,
        RATE_SLOW = 3'b100
    } rating_e;

    function automatic logic bcd_is_nine(input bcd_t d);
        return d == bcd_t'(9);
    endfunction

    function automatic bcd_t bcd_next(input bcd_t d);
        return bcd_is_nine(d) ? '0 : d + bcd_t'(1);
    endfunction

    function automatic rating_e rate_of(input bcd_t msd);
        if (msd >= bcd_t'(8))      return RATE_SLOW;
        else if (msd >= bcd_t'(4)) return RATE_MED;
        else                       return RATE_FAST;
    endfunction

endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
    parameter int unsigned TERM = rt_pkg::DEFAULT_TERM
) (
    input  logic clk,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CNT_W = (TERM < 1) ? 1 : $clog2(TERM + 1);
    localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM);

    logic [CNT_W-1:0] phase;

    assign tick = (phase == TERM_V);

    always_ff @(posedge clk) begin
        if (clr || tick) phase <= '0;
        else             phase <= phase + CNT_W'(1);
    end
endmodule

// File: rtl/rt_bcd_digit.sv
module rt_bcd_digit
    import rt_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic en,
    output bcd_t q,
    output logic at_nine
);
    assign at_nine = bcd_is_nine(q);

    always_ff @(posedge clk) begin
        if (clr)     q <= '0;
        else if (en) q <= bcd_next(q);
    end
endmodule

// File: rtl/rt_sat_counter.sv
module rt_sat_counter
    import rt_pkg::*;
#(
    parameter int unsigned N_DIG = NUM_DIGITS
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  step,
    output logic [N_DIG-1:0][DIGIT_W-1:0] digits,
    output logic                  full
);
    logic [N_DIG-1:0] nine;
    logic [N_DIG-1:0] en;

    assign full = &nine;

    generate
        for (genvar i = 0; i < N_DIG; i++) begin : g_dig
            if (i == 0) begin : g_low
                assign en[i] = step & ~full;
            end else begin : g_up
                assign en[i] = en[i-1] & nine[i-1];
            end
            rt_bcd_digit u_dig (
                .clk     (clk),
                .clr     (clr),
                .en      (en[i]),
                .q       (digits[i]),
                .at_nine (nine[i])
            );
        end
    endgenerate
endmodule

// File: rtl/rt_flags.sv
module rt_flags
    import rt_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    input  logic   cue,
    input  logic   press,
    output flags_t flags
);
    always_ff @(posedge clk) begin
        if (clr) begin
            flags <= '0;
        end else begin
            if (press)        flags.answered  <= 1'b1;
            if (press && !cue) flags.early_err <= 1'b1;
        end
    end
endmodule

// File: rtl/rt_rater.sv
module rt_rater
    import rt_pkg::*;
(
    input  bcd_t    msd,
    output rating_e rating
);
    assign rating = rate_of(msd);
endmodule

// File: rtl/reaction_timer_core.sv
module reaction_timer_core
    import rt_pkg::*;
#(
    parameter int unsigned PRESCALE_TERM = DEFAULT_TERM
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_in,
    input  logic       cue_on,
    input  logic       answer_in,
    output logic [3:0] digit_hun,
    output logic [3:0] digit_ten,
    output logic [3:0] digit_one,
    output logic       sat_flag,
    output logic       answered,
    output logic       early_err,
    output logic       rate_fast,
    output logic       rate_med,
    output logic       rate_slow
);
    logic    clr;
    logic    tick;
    logic    step;
    flags_t  flags;
    bcd3_t   count;
    rating_e rating;
    logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits;

    assign clr  = rst | start_in;
    assign step = tick & cue_on & ~flags.answered;

    rt_prescaler #(.TERM(PRESCALE_TERM)) u_presc (
        .clk  (clk),
        .clr  (clr),
        .tick (tick)
    );

    rt_sat_counter #(.N_DIG(NUM_DIGITS)) u_cnt (
        .clk    (clk),
        .clr    (clr),
        .step   (step),
        .digits (digits),
        .full   (sat_flag)
    );

    rt_flags u_flags (
        .clk   (clk),
        .clr   (clr),
        .cue   (cue_on),
        .press (answer_in),
        .flags (flags)
    );

    assign count = '{hun: digits[2], ten: digits[1], one: digits[0]};

    rt_rater u_rate (
        .msd    (count.hun),
        .rating (rating)
    );

    assign digit_hun = count.hun;
    assign digit_ten = count.ten;
    assign digit_one = count.one;
    assign answered  = flags.answered;
    assign early_err = flags.early_err;
    assign {rate_slow, rate_med, rate_fast} = rating;
endmodule

// File: rtl/rt_checker.sv
module rt_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_in,
    input logic       cue_on,
    input logic       answer_in,
    input logic [3:0] digit_hun,
    input logic [3:0] digit_ten,
    input logic [3:0] digit_one,
    input logic       sat_flag,
    input logic       answered,
    input logic       early_err,
    input logic       rate_fast,
    input logic       rate_med,
    input logic       rate_slow
);
    logic [11:0] cnt_bits;
    assign cnt_bits = {digit_hun, digit_ten, digit_one};

    AST_DIGITS_DECIMAL: assert property (@(posedge clk) disable iff (rst)
        (digit_hun <= 4'd9) && (digit_ten <= 4'd9) && (digit_one <= 4'd9)); // R1

    AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !start_in) |=> (sat_flag && $stable(cnt_bits))); // R2

    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!cue_on && !start_in) |=> $stable(cnt_bits)); // R4

    AST_ANSWER_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (answered && !start_in) |=> (answered && $stable(cnt_bits))); // R5

    AST_EARLY_STICKY: assert property (@(posedge clk) disable iff (rst)
        (early_err && !start_in) |=> early_err); // R6

    AST_EARLY_SET: assert property (@(posedge clk) disable iff (rst)
        (answer_in && !cue_on && !start_in) |=> early_err); // R6

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_in |=> (cnt_bits == 12'h000 && !answered && !early_err)); // R7

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
        $countones({rate_fast, rate_med, rate_slow}) == 1); // R9

    AST_SLOW_TOP: assert property (@(posedge clk) disable iff (rst)
        rate_slow == (digit_hun >= 4'd8)); // R9
endmodule

bind reaction_timer_core rt_checker u_rt_checker (
    .clk       (clk),
    .rst       (rst),
    .start_in  (start_in),
    .cue_on    (cue_on),
    .answer_in (answer_in),
    .digit_hun (digit_hun),
    .digit_ten (digit_ten),
    .digit_one (digit_one),
    .sat_flag  (sat_flag),
    .answered  (answered),
    .early_err (early_err),
    .rate_fast (rate_fast),
    .rate_med  (rate_med),
    .rate_slow (rate_slow)
);

// File: tb/reaction_timer_core_bench.sv
`timescale 1ns/1ps
module reaction_timer_core_bench;
    localparam int TERM = 3;
    localparam int NVEC = 11;
    // entry: {target count (12 bits), expected class {slow,med,fast}}
    localparam logic [14:0] VEC [NVEC] = '{
        {12'd0,   3'b001}, {12'd150, 3'b001}, {12'd250, 3'b001},
        {12'd399, 3'b001}, {12'd400, 3'b010}, {12'd555, 3'b010},
        {12'd650, 3'b010}, {12'd799, 3'b010}, {12'd800, 3'b100},
        {12'd950, 3'b100}, {12'd999, 3'b100}
    };

    logic clk = 1'b0;
    logic rst, start_in, cue_on, answer_in;
    logic [3:0] digit_hun, digit_ten, digit_one;
    logic sat_flag, answered, early_err, rate_fast, rate_med, rate_slow;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0, m_ph = 0;
    bit m_ans = 0, m_err = 0;

    always #2.5 clk = ~clk;

    reaction_timer_core #(.PRESCALE_TERM(TERM)) u_reaction_timer_core (
        .clk(clk), .rst(rst), .start_in(start_in), .cue_on(cue_on),
        .answer_in(answer_in), .digit_hun(digit_hun), .digit_ten(digit_ten),
        .digit_one(digit_one), .sat_flag(sat_flag), .answered(answered),
        .early_err(early_err), .rate_fast(rate_fast), .rate_med(rate_med),
        .rate_slow(rate_slow)
    );

    function automatic int dut_count();
        return digit_hun * 100 + digit_ten * 10 + digit_one;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic s, input logic c, input logic a);
        bit tk;
        rst = r; start_in = s; cue_on = c; answer_in = a;
        @(posedge clk);
        if (r || s) begin
            m_cnt = 0; m_ph = 0; m_ans = 0; m_err = 0;
        end else begin
            tk = (m_ph == TERM);
            if (tk && c && !m_ans && m_cnt < 999) m_cnt++;
            m_ph = tk ? 0 : m_ph + 1;
            if (a) m_ans = 1;
            if (a && !c) m_err = 1;
        end
        #1;
    endtask

    task automatic check_state(input string req);
        int msd;
        msd = m_cnt / 100;
        chk(dut_count() == m_cnt && digit_hun <= 9 && digit_ten <= 9 && digit_one <= 9,
            {req, " count"}, dut_count(), m_cnt);
        chk(sat_flag == (m_cnt == 999), {req, " R2 sat"}, sat_flag, m_cnt == 999);
        chk(answered == m_ans, {req, " R5 answered"}, answered, m_ans);
        chk(early_err == m_err, {req, " R6 early"}, early_err, m_err);
        chk({rate_slow, rate_med, rate_fast} == (msd >= 8 ? 3'b100 : msd >= 4 ? 3'b010 : 3'b001),
            {req, " R9 class"}, {rate_slow, rate_med, rate_fast},
            msd >= 8 ? 4 : msd >= 4 ? 2 : 1);
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int saved;
        rst = 1; start_in = 0; cue_on = 0; answer_in = 0;
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        check_state("R8 reset state");
        // R8: reset overrides cue and answer
        for (int i = 0; i < 8; i++) step(1, 0, 1, 1);
        check_state("R8 priority");

        // R3: first increment exactly on edge TERM+1 after clear
        for (int i = 0; i < TERM; i++) step(0, 0, 1, 0);
        chk(dut_count() == 0, "R3 before first tick", dut_count(), 0);
        step(0, 0, 1, 0);
        chk(dut_count() == 1, "R3 first tick", dut_count(), 1);
        for (int i = 0; i < TERM + 1; i++) step(0, 0, 1, 0);
        chk(dut_count() == 2, "R3 second tick", dut_count(), 2);

        // R1 / R9: walk the table of counts and classes
        for (int v = 0; v < NVEC; v++) begin
            while (m_cnt < int'(VEC[v][14:3])) step(0, 0, 1, 0);
            if (m_cnt == int'(VEC[v][14:3])) begin
                check_state("R1 table");
                chk({rate_slow, rate_med, rate_fast} == VEC[v][2:0], "R9 table class",
                    {rate_slow, rate_med, rate_fast}, VEC[v][2:0]);
            end
        end

        // R2: hold at 999
        for (int i = 0; i < 40; i++) step(0, 0, 1, 0);
        chk(dut_count() == 999 && sat_flag, "R2 saturate hold", dut_count(), 999);
        check_state("R2 after hold");

        // R7: start clears with cue still high
        step(0, 1, 1, 0);
        check_state("R7 start clear");
        chk(dut_count() == 0 && !sat_flag, "R7 count zero", dut_count(), 0);

        // R4: no counting with cue low
        for (int i = 0; i < 20; i++) step(0, 0, 0, 0);
        chk(dut_count() == 0, "R4 idle cue low", dut_count(), 0);

        // R5: answer freezes count; tick on the answering edge counts
        step(0, 1, 0, 0);
        for (int i = 0; i < 4 * (TERM + 1) - 1; i++) step(0, 0, 1, 0);
        step(0, 0, 1, 1);
        chk(dut_count() == 4 && answered, "R5 tick at answer edge", dut_count(), 4);
        saved = dut_count();
        for (int i = 0; i < 40; i++) step(0, 0, 1, 0);
        chk(dut_count() == saved, "R5 frozen", dut_count(), saved);
        chk(!early_err, "R6 no error with cue", early_err, 0);
        check_state("R5 after freeze");

        // R6: early press sets error, sticky; count stays zero after cue
        step(0, 1, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
        step(0, 0, 0, 1);
        chk(early_err && answered, "R6 early set", early_err, 1);
        for (int i = 0; i < 30; i++) step(0, 0, 1, 0);
        chk(early_err, "R6 sticky", early_err, 1);
        chk(dut_count() == 0, "R4 no count after answer", dut_count(), 0);
        check_state("R6 after cue");

        // R7: start clears the error
        step(0, 1, 0, 0);
        chk(!early_err && !answered, "R7 flags cleared", early_err, 0);

        // R8: reset in the middle of counting
        for (int i = 0; i < 50; i++) step(0, 0, 1, 0);
        step(1, 0, 1, 0);
        check_state("R8 mid-count reset");
        chk(dut_count() == 0, "R8 count zero", dut_count(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule